// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block runs one 16-bit processor bus cycle on a bus that carries both address and data. A cycle moves through the phases T1, T2 and T3, then zero or more wait phases TW, then T4. The block drives a byte-enable line and the bus bit 0. From these two lines the system can tell word, high-byte, low-byte and refresh cycles apart. It also decides, phase by phase, which halves of the shared bus carry address.

A configuration strap is captured while reset is held. When the strap is high, the address phase can be suppressed for cycles to the lower or upper chip-select region through per-region disable bits. When the strap is low, the address is always driven.

Wait states come from two sources. One is a synchronous ready input. The other is an asynchronous ready input, which passes through an internal synchronizer. The block reports the active phase as a one-hot vector, holds the address of the cycle, and raises a done flag during T4. Address decode, data movement, DRAM timing and clock generation belong to other blocks.

Top module: `mxbus_seq`

## Requirements
- R1: After a request is accepted, `phase` steps one phase per clock: T1 (bit 0), T2 (bit 1), T3 (bit 2), optional TW (bit 3), then T4 (bit 4), then all zero (idle). At most one bit is ever set.
- R2: In T1 the pair {`bhe_n`, `ad_out[0]`} encodes the transfer. A word transfer gives 0,0 and forces bit 0 low. A byte transfer with odd address gives 0,1 (high byte, bits 15..8). A byte transfer with even address gives 1,0 (low byte, bits 7..0).
- R3: A refresh cycle drives `bhe_n`=1 and `ad_out`=FFFFh in T1, with both bus halves enabled.
- R4: `bhe_oe` is high in T1, T2, T3 and TW. It is low in T4, in idle and during reset.
- R5: `addr_strap` is captured on every clock while `rst` is high, so the value held at release applies. Changes after release have no effect. With a captured low strap, the address is driven in T1 whatever the disable bits say.
- R6: With a captured high strap, a cycle to region 1 (lower) with `dis_addr_lo` set, or to region 2 (upper) with `dis_addr_hi` set, leaves both `ad_oe_hi` and `ad_oe_lo` low in T1. A disable bit for the other region has no effect.
- R7: For a byte transfer, `ad_oe_hi` is high and `ad_out[15:8]` carries address bits 15..8 in T2, T3, TW and T4, even when the address was suppressed in T1. A word transfer leaves `ad_oe_hi` low in those phases.
- R8: Combined ready is `srdy` OR the synchronized `ardy`. It is sampled on each rising edge in T3 and TW. When it is low the next phase is TW. When it is high the next phase is T4.
- R9: `ardy` passes through a two-flop synchronizer. A rise of `ardy` before edge k lets the cycle leave TW at edge k+2, so T4 is seen after the third edge.
- R10: `done` is high exactly during T4. `lat_addr` holds the request address from T1 through T4.
- R11: While `bus_hold` is high in idle, a request is not started and `phase` stays zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also captures the strap |
| addr_strap | input | 1 | Address-suppression strap, captured during reset |
| req | input | 1 | Start a bus cycle (taken in idle) |
| req_addr | input | 16 | Cycle address |
| req_byte | input | 1 | 1 = 8-bit transfer, 0 = word |
| req_refresh | input | 1 | 1 = refresh cycle |
| req_region | input | 2 | 0 none, 1 lower region, 2 upper region |
| dis_addr_lo | input | 1 | Suppress address for lower-region cycles |
| dis_addr_hi | input | 1 | Suppress address for upper-region cycles |
| bus_hold | input | 1 | Bus granted away; no cycle starts |
| srdy | input | 1 | Synchronous ready |
| ardy | input | 1 | Asynchronous ready, active high |
| phase | output | 5 | One-hot phase: T1,T2,T3,TW,T4 from bit 0 |
| bhe_n | output | 1 | Byte high enable, active low |
| bhe_oe | output | 1 | Drive enable for `bhe_n` |
| ad_out | output | 16 | Value driven on the shared bus |
| ad_oe_hi | output | 1 | Drive enable for bus bits 15..8 |
| ad_oe_lo | output | 1 | Drive enable for bus bits 7..0 |
| lat_addr | output | 16 | Address of the current cycle |
| done | output | 1 | Cycle finishing (T4) |

## Verification
Every output is a registered state or a combinational decode of registered state. The bench drives inputs on the falling edge and reads outputs on the next falling edge. A request placed before edge k therefore shows T1 at the following falling edge, and each later phase one falling edge after the one before it. The T3 ready sample falls on the third edge after acceptance. Two extra edges apply for `ardy`, because of its two synchronizer flops, so the bench expects two TW samples after raising it before T4 appears. Each scenario task walks the phases one falling edge at a time and checks the outputs due in that phase.

// File: rtl/mxbus_pkg.sv
package mxbus_pkg;

    localparam int ADDR_W = 16;
    localparam int HALF_W = ADDR_W / 2;
    localparam int NPH    = 5;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_T1   = 3'd1,
        PH_T2   = 3'd2,
        PH_T3   = 3'd3,
        PH_TW   = 3'd4,
        PH_T4   = 3'd5
    } phase_e;

    typedef enum logic [1:0] {
        RGN_NONE  = 2'd0,
        RGN_LOWER = 2'd1,
        RGN_UPPER = 2'd2,
        RGN_RSVD  = 2'd3
    } region_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              is_byte;
        logic              is_refresh;
        region_e           region;
        logic              dis_lo;
        logic              dis_hi;
    } cyc_t;

    function automatic logic [NPH-1:0] phase_onehot(input phase_e p);
        logic [NPH-1:0] v;
        v = '0;
        case (p)
            PH_T1:   v[0] = 1'b1;
            PH_T2:   v[1] = 1'b1;
            PH_T3:   v[2] = 1'b1;
            PH_TW:   v[3] = 1'b1;
            PH_T4:   v[4] = 1'b1;
            default: v = '0;
        endcase
        return v;
    endfunction

    function automatic logic in_data_phase(input phase_e p);
        return (p == PH_T2) || (p == PH_T3) || (p == PH_TW) || (p == PH_T4);
    endfunction

endpackage

// File: rtl/mxbus_rdy_sync.sv
module mxbus_rdy_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= din;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];

endmodule

// File: rtl/mxbus_phase_fsm.sv
module mxbus_phase_fsm
    import mxbus_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   req,
    input  logic   bus_hold,
    input  logic   rdy,
    input  cyc_t   req_cyc,
    output phase_e state,
    output cyc_t   cyc
);
    phase_e state_nx;

    always_comb begin
        state_nx = state;
        case (state)
            PH_IDLE: if (req && !bus_hold) state_nx = PH_T1;
            PH_T1:   state_nx = PH_T2;
            PH_T2:   state_nx = PH_T3;
            PH_T3:   state_nx = rdy ? PH_T4 : PH_TW;
            PH_TW:   state_nx = rdy ? PH_T4 : PH_TW;
            PH_T4:   state_nx = PH_IDLE;
            default: state_nx = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PH_IDLE;
            cyc   <= '0;
        end else begin
            state <= state_nx;
            if (state == PH_IDLE && req && !bus_hold)
                cyc <= req_cyc;
        end
    end

    AST_PHASE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(phase_onehot(state)));                                   // R1
    AST_T1_THEN_T2: assert property (@(posedge clk) disable iff (rst)
        (state == PH_T1) |=> (state == PH_T2));                           // R1
    AST_T3_WAIT: assert property (@(posedge clk) disable iff (rst)
        (state == PH_T3 && !rdy) |=> (state == PH_TW));                   // R8
    AST_TW_EXIT: assert property (@(posedge clk) disable iff (rst)
        (state == PH_TW && rdy) |=> (state == PH_T4));                    // R8
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
        (state != PH_IDLE && state != PH_T1) |-> $stable(cyc.addr));      // R10

endmodule

// File: rtl/mxbus_drive.sv
module mxbus_drive
    import mxbus_pkg::*;
(
    input  phase_e              state,
    input  cyc_t                cyc,
    input  logic                strap_q,
    output logic                bhe_n,
    output logic                bhe_oe,
    output logic [ADDR_W-1:0]   ad_out,
    output logic                ad_oe_hi,
    output logic                ad_oe_lo
);
    logic suppress;
    logic enc_bhe_n;

    always_comb begin
        suppress = strap_q && !cyc.is_refresh &&
                   (((cyc.region == RGN_LOWER) && cyc.dis_lo) ||
                    ((cyc.region == RGN_UPPER) && cyc.dis_hi));
        if (cyc.is_refresh)   enc_bhe_n = 1'b1;
        else if (cyc.is_byte) enc_bhe_n = ~cyc.addr[0];
        else                  enc_bhe_n = 1'b0;
    end

    always_comb begin
        bhe_oe   = (state == PH_T1) || (state == PH_T2) ||
                   (state == PH_T3) || (state == PH_TW);
        bhe_n    = bhe_oe ? enc_bhe_n : 1'b1;
        ad_out   = '0;
        ad_oe_hi = 1'b0;
        ad_oe_lo = 1'b0;
        if (state == PH_T1) begin
            if (cyc.is_refresh) begin
                ad_out   = '1;
                ad_oe_hi = 1'b1;
                ad_oe_lo = 1'b1;
            end else begin
                ad_out   = {cyc.addr[ADDR_W-1:1], cyc.is_byte & cyc.addr[0]};
                ad_oe_hi = !suppress;
                ad_oe_lo = !suppress;
            end
        end else if (in_data_phase(state) && cyc.is_byte && !cyc.is_refresh) begin
            ad_out[ADDR_W-1:HALF_W] = cyc.addr[ADDR_W-1:HALF_W];
            ad_oe_hi                = 1'b1;
        end
    end

endmodule

// File: rtl/mxbus_seq.sv
module mxbus_seq
    import mxbus_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              addr_strap,
    input  logic              req,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_byte,
    input  logic              req_refresh,
    input  logic [1:0]        req_region,
    input  logic              dis_addr_lo,
    input  logic              dis_addr_hi,
    input  logic              bus_hold,
    input  logic              srdy,
    input  logic              ardy,
    output logic [NPH-1:0]    phase,
    output logic              bhe_n,
    output logic              bhe_oe,
    output logic [ADDR_W-1:0] ad_out,
    output logic              ad_oe_hi,
    output logic              ad_oe_lo,
    output logic [ADDR_W-1:0] lat_addr,
    output logic              done
);
    logic   strap_q;
    logic   ardy_s;
    logic   rdy;
    cyc_t   req_cyc;
    cyc_t   cyc;
    phase_e state;

    always_ff @(posedge clk) begin
        if (rst) strap_q <= addr_strap;
    end

    mxbus_rdy_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (ardy),
        .dout (ardy_s)
    );

    assign rdy = srdy | ardy_s;

    always_comb begin
        req_cyc.addr       = req_addr;
        req_cyc.is_byte    = req_byte;
        req_cyc.is_refresh = req_refresh;
        req_cyc.region     = region_e'(req_region);
        req_cyc.dis_lo     = dis_addr_lo;
        req_cyc.dis_hi     = dis_addr_hi;
    end

    mxbus_phase_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .bus_hold (bus_hold),
        .rdy      (rdy),
        .req_cyc  (req_cyc),
        .state    (state),
        .cyc      (cyc)
    );

    mxbus_drive u_drive (
        .state    (state),
        .cyc      (cyc),
        .strap_q  (strap_q),
        .bhe_n    (bhe_n),
        .bhe_oe   (bhe_oe),
        .ad_out   (ad_out),
        .ad_oe_hi (ad_oe_hi),
        .ad_oe_lo (ad_oe_lo)
    );

    assign phase    = phase_onehot(state);
    assign lat_addr = cyc.addr;
    assign done     = (state == PH_T4);

    AST_BHE_FLOAT_T4: assert property (@(posedge clk) disable iff (rst)
        phase[4] |-> !bhe_oe);                                            // R4
    AST_REFRESH_ONES: assert property (@(posedge clk) disable iff (rst)
        (phase[0] && bhe_n && ad_out[0]) |-> (ad_out == '1 && ad_oe_lo)); // R3
    AST_DONE_IN_T4: assert property (@(posedge clk) disable iff (rst)
        done |-> (phase == 5'b10000));                                    // R10
    AST_HOLD_NOSTART: assert property (@(posedge clk) disable iff (rst)
        (phase == '0 && bus_hold) |=> (phase == '0));                     // R11
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (phase == '0) |-> (!ad_oe_hi && !ad_oe_lo && !bhe_oe));           // R4

endmodule

// File: tb/mxbus_seq_bench.sv
module mxbus_seq_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        addr_strap, req, req_byte, req_refresh;
    logic [15:0] req_addr;
    logic [1:0]  req_region;
    logic        dis_addr_lo, dis_addr_hi, bus_hold, srdy, ardy;
    logic [4:0]  phase;
    logic        bhe_n, bhe_oe, ad_oe_hi, ad_oe_lo, done;
    logic [15:0] ad_out, lat_addr;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    always #5 clk = ~clk;

    mxbus_seq u_mxbus_seq (
        .clk(clk), .rst(rst), .addr_strap(addr_strap), .req(req),
        .req_addr(req_addr), .req_byte(req_byte), .req_refresh(req_refresh),
        .req_region(req_region), .dis_addr_lo(dis_addr_lo), .dis_addr_hi(dis_addr_hi),
        .bus_hold(bus_hold), .srdy(srdy), .ardy(ardy), .phase(phase),
        .bhe_n(bhe_n), .bhe_oe(bhe_oe), .ad_out(ad_out), .ad_oe_hi(ad_oe_hi),
        .ad_oe_lo(ad_oe_lo), .lat_addr(lat_addr), .done(done)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_reset(input logic strap);
        rst = 1'b1; addr_strap = strap; req = 0;
        repeat (3) step();
        chk("R4 reset phase", phase, 5'b0);
        chk("R4 reset bhe_oe", bhe_oe, 0);
        chk("R4 reset ad_oe", {ad_oe_hi, ad_oe_lo}, 2'b00);
        rst = 1'b0;
        step();
    endtask

    // Presents a request for one edge; returns at the falling edge showing T1.
    task automatic launch(input logic [15:0] a, input logic byt, input logic rf, input logic [1:0] rg);
        req = 1; req_addr = a; req_byte = byt; req_refresh = rf; req_region = rg;
        step();
        req = 0; req_addr = 16'h0;
    endtask

    task automatic t_word();
        launch(16'h1234, 0, 0, 2'd0);
        chk("R1 T1", phase, 5'b00001);
        chk("R2 word enc", {bhe_n, ad_out[0]}, 2'b00);
        chk("R2 word addr", ad_out, 16'h1234);
        chk("R4 bhe_oe T1", bhe_oe, 1);
        step(); chk("R1 T2", phase, 5'b00010);
        chk("R7 word hi off", ad_oe_hi, 0);
        step(); chk("R1 T3", phase, 5'b00100);
        chk("R4 bhe_oe T3", bhe_oe, 1);
        step(); chk("R1 T4", phase, 5'b10000);
        chk("R10 done", done, 1);
        chk("R10 lat_addr", lat_addr, 16'h1234);
        chk("R4 bhe_oe T4", bhe_oe, 0);
        step(); chk("R1 idle", phase, 5'b0);
        chk("R10 done idle", done, 0);
    endtask

    task automatic t_bytes();
        launch(16'hA5C3, 1, 0, 2'd0);
        chk("R2 high byte enc", {bhe_n, ad_out[0]}, 2'b01);
        repeat (4) step();
        launch(16'h5A42, 1, 0, 2'd0);
        chk("R2 low byte enc", {bhe_n, ad_out[0]}, 2'b10);
        step();
        chk("R7 byte hi T2", {ad_oe_hi, ad_oe_lo, ad_out}, {2'b10, 16'h5A00});
        step(); step();
        chk("R7 byte hi T4", {ad_oe_hi, ad_out[15:8]}, {1'b1, 8'h5A});
        step();
    endtask

    task automatic t_refresh();
        launch(16'h0040, 0, 1, 2'd0);
        chk("R3 refresh enc", {bhe_n, ad_out}, {1'b1, 16'hFFFF});
        chk("R3 refresh oe", {ad_oe_hi, ad_oe_lo}, 2'b11);
        repeat (4) step();
    endtask

    task automatic t_suppress();
        dis_addr_lo = 1; dis_addr_hi = 0;
        launch(16'h0100, 0, 0, 2'd1);
        chk("R6 lower suppressed", {ad_oe_hi, ad_oe_lo}, 2'b00);
        repeat (4) step();
        launch(16'h8100, 0, 0, 2'd2);
        chk("R6 upper unaffected", {ad_oe_hi, ad_oe_lo}, 2'b11);
        repeat (4) step();
        dis_addr_lo = 0; dis_addr_hi = 1;
        launch(16'hBE01, 1, 0, 2'd2);
        chk("R6 upper suppressed", {ad_oe_hi, ad_oe_lo}, 2'b00);
        step();
        chk("R7 byte hi after suppress", {ad_oe_hi, ad_out}, {1'b1, 16'hBE00});
        repeat (3) step();
        dis_addr_hi = 0;
    endtask

    task automatic t_srdy_wait();
        srdy = 0;
        launch(16'h2222, 0, 0, 2'd0);
        step(); step();
        chk("R8 T3 not ready", phase, 5'b00100);
        step(); chk("R8 TW", phase, 5'b01000);
        chk("R4 bhe_oe TW", bhe_oe, 1);
        step(); chk("R8 TW held", phase, 5'b01000);
        srdy = 1;
        step(); chk("R8 T4 after srdy", phase, 5'b10000);
        step();
    endtask

    task automatic t_ardy_wait();
        srdy = 0; ardy = 0;
        launch(16'h3333, 0, 0, 2'd0);
        repeat (3) step();
        chk("R9 TW before ardy", phase, 5'b01000);
        ardy = 1;
        step(); chk("R9 TW sync edge 1", phase, 5'b01000);
        step(); chk("R9 TW sync edge 2", phase, 5'b01000);
        step(); chk("R9 T4 third edge", phase, 5'b10000);
        ardy = 0;
        repeat (4) step();
        launch(16'h3334, 0, 0, 2'd0);
        repeat (3) step();
        chk("R8 ardy low waits", phase, 5'b01000);
        srdy = 1;
        repeat (2) step();
    endtask

    task automatic t_hold();
        bus_hold = 1;
        req = 1; req_addr = 16'h4444; req_byte = 0; req_refresh = 0; req_region = 0;
        step(); chk("R11 hold no start", phase, 5'b0);
        step(); chk("R11 hold outputs", {bhe_oe, ad_oe_hi, ad_oe_lo}, 3'b000);
        bus_hold = 0;
        step(); chk("R11 start after hold", phase, 5'b00001);
        req = 0;
        repeat (4) step();
    endtask

    task automatic t_strap_low();
        do_reset(1'b0);
        addr_strap = 1;
        dis_addr_lo = 1;
        launch(16'h0200, 0, 0, 2'd1);
        chk("R5 strap low drives", {ad_oe_hi, ad_oe_lo}, 2'b11);
        repeat (4) step();
        dis_addr_lo = 0;
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst = 1; addr_strap = 1; req = 0; req_addr = 0; req_byte = 0; req_refresh = 0;
        req_region = 0; dis_addr_lo = 0; dis_addr_hi = 0; bus_hold = 0; srdy = 1; ardy = 0;
        step();
        do_reset(1'b1);
        t_word();
        t_bytes();
        t_refresh();
        t_suppress();
        t_srdy_wait();
        t_ardy_wait();
        t_hold();
        t_strap_low();
        finish_run();
    end
endmodule